// File: doc/BRIEF.md
# DMA Channel Service Arbiter

This block decides which DMA channel the transfer engine serves next. Each cycle it looks at the per-channel request vector and picks one winner. In fixed mode it ranks channels by a group number and then by a priority level. In rotating mode it takes turns among the requesting channels. The chosen channel stays granted until the engine reports that the channel's minor loop has finished.

While a channel runs in fixed mode, a more urgent requester can suspend it, provided both sides permit this. The suspended channel is resumed directly when the preempting channel completes. Only one channel can be held suspended at a time.

A global halt state, latched by an error pulse when halting is enabled, blocks every new service. A debug stall input blocks new starts but lets the running channel finish.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, `grant_vld`, `preempt_req` and `halted` are 0, and the rotating pointer sits so that channel 0 is the first candidate.
- R2: In fixed mode (`rr_mode`=0), the requesting channel with the numerically highest group value (`group_lvl` field i, bits i*GRP_W upward) wins.
- R3: In fixed mode, channels with the same group are ranked by priority level (`prio_lvl` field i, bits i*PRI_W upward), higher value winning; a full tie goes to the lower channel index.
- R4: In rotating mode (`rr_mode`=1), the winner is the first requesting channel found when searching upward, with wrap-around, from the channel after the last one granted; channels that are not requesting are skipped.
- R5: A winner found while idle is granted one cycle later: `grant_vld`=1 and `grant_idx` equals the winner. The grant holds until `ch_done` is seen. After a `ch_done` with nothing suspended, `grant_vld` is 0 for at least one cycle.
- R6: In fixed mode, `preempt_req` is asserted combinationally only when all of the following hold: a channel is running and nothing is suspended; `ch_done` is low; the current winner has its `preempt_ok` bit set; the winner's {group, priority} value is strictly greater than that of the running channel; and the running channel's `suspendable` bit is set. On the next cycle the winner is granted and the previous channel is held as suspended.
- R7: When `ch_done` arrives while a channel is suspended, the suspended channel is granted again on the next cycle, with no idle cycle and ahead of any other request.
- R8: With `halt_on_err_en`=1, `err_pulse` sets `halted` on the next cycle; with `halt_on_err_en`=0 the pulse has no effect. While `halted` is set, no new grant and no preemption occur. `halt_clr` clears `halted`, but a simultaneous error wins.
- R9: While `dbg_stall`=1, no new channel is started and no preemption occurs, but the running channel keeps its grant until `ch_done`.
- R10: In rotating mode, `preempt_req` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NCH | Per-channel service requests |
| rr_mode | input | 1 | 1 selects rotating arbitration, 0 selects fixed priority |
| halt_on_err_en | input | 1 | Allow errors to latch the halt state |
| group_lvl | input | NCH*GRP_W | Per-channel group numbers, packed |
| prio_lvl | input | NCH*PRI_W | Per-channel priority levels, packed |
| suspendable | input | NCH | Channel i may be suspended by a more urgent one |
| preempt_ok | input | NCH | Channel i may suspend a less urgent one |
| err_pulse | input | 1 | Transfer error event |
| halt_clr | input | 1 | Clears the halt state |
| dbg_stall | input | 1 | Block starts of new channels |
| ch_done | input | 1 | Granted channel finished its minor loop |
| grant_idx | output | $clog2(NCH) | Index of the channel being served |
| grant_vld | output | 1 | A channel is being served |
| preempt_req | output | 1 | Suspend the running channel in favour of the winner |
| halted | output | 1 | Halt state |

## Verification
The assertions assume the following about the inputs:
- `ch_done` is raised only while `grant_vld` is high.
- `group_lvl`, `prio_lvl`, `suspendable`, `preempt_ok` and `rr_mode` change only while the block is idle or between test phases, not in the middle of a grant that the checks are reasoning about.

The stimulus keeps to these rules: it pulses `ch_done` only after a grant is visible, and it reprograms configuration only after a completion has returned the block to idle. Every cycle, the bench compares the outputs with a behavioural model of grant, suspension and halt.

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int NCH   = 4,
  parameter int GRP_W = 2,
  parameter int PRI_W = 3,
  localparam int IW   = $clog2(NCH),
  localparam int KW   = GRP_W + PRI_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     req,
  input  logic               rr_mode,
  input  logic               halt_on_err_en,
  input  logic [NCH*GRP_W-1:0] group_lvl,
  input  logic [NCH*PRI_W-1:0] prio_lvl,
  input  logic [NCH-1:0]     suspendable,
  input  logic [NCH-1:0]     preempt_ok,
  input  logic               err_pulse,
  input  logic               halt_clr,
  input  logic               dbg_stall,
  input  logic               ch_done,
  output logic [IW-1:0]      grant_idx,
  output logic               grant_vld,
  output logic               preempt_req,
  output logic               halted
);

  logic [KW-1:0] key [NCH];
  logic          busy, susp;
  logic [IW-1:0] cur, held, last;
  logic [IW-1:0] win;
  logic          win_vld;
  logic [KW-1:0] best;

  for (genvar g = 0; g < NCH; g++) begin : g_key
    assign key[g] = {group_lvl[g*GRP_W +: GRP_W], prio_lvl[g*PRI_W +: PRI_W]};
  end

  always_comb begin
    win     = '0;
    win_vld = 1'b0;
    best    = '0;
    if (rr_mode) begin
      for (int i = 1; i <= NCH; i++) begin
        if (!win_vld && req[(int'(last) + i) % NCH]) begin
          win_vld = 1'b1;
          win     = IW'((int'(last) + i) % NCH);
        end
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (req[i] && (!win_vld || key[i] > best)) begin
          win_vld = 1'b1;
          win     = IW'(i);
          best    = key[i];
        end
      end
    end
  end

  assign preempt_req = busy && !susp && !rr_mode && !halted && !dbg_stall && !ch_done &&
                       win_vld && preempt_ok[win] && suspendable[cur] && (key[win] > key[cur]);

  wire start = !busy && !halted && !dbg_stall && win_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      susp   <= 1'b0;
      cur    <= '0;
      held   <= '0;
      last   <= IW'(NCH - 1);
      halted <= 1'b0;
    end else begin
      if (halt_on_err_en && err_pulse) halted <= 1'b1;
      else if (halt_clr)               halted <= 1'b0;

      if (busy && ch_done) begin
        if (susp) begin
          cur  <= held;
          susp <= 1'b0;
        end else begin
          busy <= 1'b0;
        end
      end else if (preempt_req) begin
        held <= cur;
        susp <= 1'b1;
        cur  <= win;
        last <= win;
      end else if (start) begin
        busy <= 1'b1;
        cur  <= win;
        last <= win;
      end
    end
  end

  assign grant_idx = cur;
  assign grant_vld = busy;

endmodule

// File: rtl/dma_chan_arbiter_chk.sv
module dma_chan_arbiter_chk #(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req,
  input logic           rr_mode,
  input logic           halt_on_err_en,
  input logic [NCH-1:0] suspendable,
  input logic           err_pulse,
  input logic           dbg_stall,
  input logic [IW-1:0]  grant_idx,
  input logic           grant_vld,
  input logic           preempt_req,
  input logic           halted
);

  logic [NCH-1:0] req_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) req_q <= '0;
    else        req_q <= req;

  // R5
  fresh_grant_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) |-> req_q[grant_idx]);

  // R6
  preempt_switches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_req |=> grant_vld && grant_idx != $past(grant_idx));

  // R6
  preempt_needs_suspendable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_req |-> grant_vld && suspendable[grant_idx]);

  // R8
  halt_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !grant_vld) |=> !grant_vld);

  // R8
  halt_from_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(err_pulse && halt_on_err_en));

  // R9
  debug_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_stall && !grant_vld) |=> !grant_vld);

  // R10
  no_rr_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rr_mode |-> !preempt_req);

endmodule

bind dma_chan_arbiter dma_chan_arbiter_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/tb_dma_chan_arbiter.sv
module tb_dma_chan_arbiter;
  localparam int N = 4, GW = 2, PW = 3, IW = 2;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [N-1:0] req = '0, suspendable = '0, preempt_ok = '0;
  logic rr_mode = 0, halt_on_err_en = 1, err_pulse = 0, halt_clr = 0, dbg_stall = 0, ch_done = 0;
  int grp [N], pri [N];
  logic [N*GW-1:0] group_lvl;
  logic [N*PW-1:0] prio_lvl;
  logic [IW-1:0] grant_idx;
  logic grant_vld, preempt_req, halted;

  always_comb
    for (int i = 0; i < N; i++) begin
      group_lvl[i*GW +: GW] = GW'(grp[i]);
      prio_lvl[i*PW +: PW]  = PW'(pri[i]);
    end

  dma_chan_arbiter dut (.*);

  int tests = 0, fails = 0;
  string tag = "R1";
  int m_busy, m_cur, m_susp, m_held, m_halt, m_last;

  function automatic int keyof(int c);
    return grp[c] * 8 + pri[c];
  endfunction

  function automatic int pick();
    int b = -1;
    if (rr_mode) begin
      for (int i = 1; i <= N; i++)
        if (req[(m_last + i) % N]) return (m_last + i) % N;
      return -1;
    end
    for (int i = 0; i < N; i++)
      if (req[i] && (b < 0 || keyof(i) > keyof(b))) b = i;
    return b;
  endfunction

  function automatic int exp_pe();
    int w = pick();
    return (m_busy && !m_susp && !rr_mode && !m_halt && !dbg_stall && !ch_done && w >= 0 &&
            preempt_ok[w] && suspendable[m_cur] && keyof(w) > keyof(m_cur)) ? 1 : 0;
  endfunction

  task automatic chk(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_busy = 0; m_cur = 0; m_susp = 0; m_held = 0; m_halt = 0; m_last = N - 1;
  endtask

  task automatic step();
    int w, pe;
    #1;
    w  = pick();
    pe = exp_pe();
    chk("grant_vld", int'(grant_vld), m_busy);
    if (m_busy) chk("grant_idx", int'(grant_idx), m_cur);
    chk("preempt_req", int'(preempt_req), pe);
    chk("halted", int'(halted), m_halt);
    @(posedge clk);
    if (rst_n) begin
      if (m_busy && ch_done) begin
        if (m_susp) begin m_cur = m_held; m_susp = 0; end
        else m_busy = 0;
      end else if (pe) begin
        m_held = m_cur; m_susp = 1; m_cur = w; m_last = w;
      end else if (!m_busy && !m_halt && !dbg_stall && w >= 0) begin
        m_busy = 1; m_cur = w; m_last = w;
      end
      if (halt_on_err_en && err_pulse) m_halt = 1;
      else if (halt_clr) m_halt = 0;
    end
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic done_pulse();
    ch_done = 1; step(); ch_done = 0;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin grp[i] = 0; pri[i] = 0; end
    model_reset();
    @(negedge clk);
    tag = "R1"; req = 4'b1111;
    run(2);
    rst_n = 1; req = '0;
    run(2);

    tag = "R2";
    grp[0] = 1; grp[1] = 3; grp[2] = 2; grp[3] = 0;
    req = 4'b1111;
    run(3);
    done_pulse(); run(2);
    req = 4'b1101;
    done_pulse(); run(2);
    req = 4'b1001;
    done_pulse(); run(2);
    req = 0; done_pulse(); run(2);

    tag = "R3";
    for (int i = 0; i < N; i++) grp[i] = 0;
    pri[0] = 2; pri[1] = 5; pri[2] = 5; pri[3] = 1;
    req = 4'b1111; run(3);
    req = 4'b1101; done_pulse(); run(2);
    req = 4'b1001; done_pulse(); run(2);
    req = 0; done_pulse(); run(2);

    tag = "R4";
    rr_mode = 1; req = 4'b1011;
    for (int k = 0; k < 6; k++) begin run(2); done_pulse(); end
    req = 4'b0100; run(2); done_pulse();
    req = 0; run(2);

    tag = "R10";
    suspendable = '1; preempt_ok = '1;
    req = 4'b0001; run(2);
    req = 4'b1001; pri[3] = 7; grp[3] = 3; run(3);
    req = 0; done_pulse(); run(2);

    tag = "R6";
    rr_mode = 0;
    for (int i = 0; i < N; i++) begin grp[i] = 0; pri[i] = i; end
    suspendable = 4'b0000; preempt_ok = 4'b1111;
    req = 4'b0001; run(2);
    req = 4'b1001; run(3);
    req = 0; done_pulse(); run(2);
    suspendable = 4'b0001; preempt_ok = 4'b0000;
    req = 4'b0001; run(2);
    req = 4'b1001; run(3);
    req = 0; done_pulse(); run(2);
    preempt_ok = 4'b1000;
    req = 4'b0001; run(2);
    req = 4'b1001; run(3);

    tag = "R7";
    req = 4'b0101; done_pulse(); run(3);
    req = 0; done_pulse(); run(2);

    tag = "R5";
    suspendable = 0; preempt_ok = 0;
    req = 4'b0010; run(4);
    req = 0; run(3);
    done_pulse(); run(2);

    tag = "R8";
    halt_on_err_en = 0; err_pulse = 1; step(); err_pulse = 0; run(2);
    halt_on_err_en = 1; err_pulse = 1; step(); err_pulse = 0;
    req = 4'b0100; run(4);
    halt_clr = 1; err_pulse = 1; step(); err_pulse = 0; run(2);
    step(); halt_clr = 0; run(3);
    req = 0; done_pulse(); run(2);

    tag = "R9";
    req = 4'b0001; run(2);
    dbg_stall = 1; preempt_ok = '1; suspendable = '1;
    req = 4'b1001; run(3);
    req = 4'b1000; done_pulse(); run(4);
    dbg_stall = 0; run(3);
    req = 0; done_pulse(); run(2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule